// File: doc/BRIEF.md
# Interrupt Mask and Reset Controller

This block sits at the top of a device made of several subsystems. Each subsystem raises one composite interrupt line. The block gates those lines with a read/write mask register and combines the ones that pass into a single active-high interrupt pin. A mask bit at 1 blocks its source and a mask bit at 0 lets it through. After reset every source is masked.

A second, write-only control register drives two reset outputs. Setting its monitor bit starts a long reset pulse for the performance monitor. The pulse length is a cycle count derived from the clock frequency and a 500 ms interval. Writing an exact three-bit code into its low field requests a device-wide software reset. That reset is a registered pulse of a few cycles. While the pulse lasts, this block also returns to its reset state, as a hardware reset would put it.

Top module: `irq_rst_ctl`

## Requirements
- R1: After reset, a read of the mask address returns 0xFFFF, and `irq_o`, `mon_rst_o` and `sw_rst_o` are all 0.
- R2: A bus write to the mask address (address 0) with `bus_we` high stores all 16 data bits. The value reads back from the next cycle on. Reads are combinational on `bus_addr`.
- R3: `irq_o` is 1 exactly when at least one implemented source is high and its mask bit is 0. The implemented sources are at bit positions 15, 11, 10, 9, 8, 7, 6, 1 and 0 of `src_irq`, and each is masked by the same bit position of the mask.
- R4: Inputs at the reserved positions 14:12 and 5:2 of `src_irq` never raise `irq_o`, whatever the mask holds.
- R5: A read of the control address (address 1), or of any address other than the mask address, returns 0.
- R6: A write to the control address with bit 7 set raises `mon_rst_o` in the next cycle. The output stays high for exactly MON_CYCLES cycles and then falls by itself.
- R7: Setting bit 7 again while the monitor pulse is running restarts the count, so the pulse ends MON_CYCLES cycles after the later write.
- R8: A write to the control address with bits 2:0 equal to binary 101 raises `sw_rst_o` in the next cycle for exactly SW_LEN cycles. Any other value in bits 2:0 leaves `sw_rst_o` low.
- R9: While `sw_rst_o` is high, the mask returns to 0xFFFF, any running monitor pulse ends, and all bus writes are ignored.
- R10: A single control write that carries both bit 7 and the code 101 starts only the software reset. It starts no monitor pulse.
- R11: With `bus_we` low, address and data on the bus change neither the mask nor the reset outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data (combinational) |
| src_irq | input | 16 | Composite interrupt inputs by bit position |
| irq_o | output | 1 | Combined interrupt pin, active high |
| mon_rst_o | output | 1 | Performance-monitor reset pulse |
| sw_rst_o | output | 1 | Device-wide software reset request |

## Verification
The bound checker tests these points on every cycle:
- A fully masked bank and reserved-only inputs keep the pin quiet.
- A monitor-bit write or a code write raises its output on the next cycle.
- A non-matching code never starts a software reset.
- The mask returns to its default during a software reset, and the monitor output is low then.
- The control address reads zero.

Only the bench scenarios can show the exact pulse lengths and the restart of the monitor count. They also cover the combined write that starts no monitor pulse, writes that are lost during a software reset, and the randomized agreement of the pin with a model of the mask.

// File: rtl/irq_rst_pkg.sv
package irq_rst_pkg;

   // Decoded bus actions for one cycle
   typedef struct packed {
      logic wr_mask;    // store write data into the mask
      logic code_hit;   // software reset code written
      logic mon_start;  // (re)start the monitor pulse
   } bus_act_t;

   function automatic int unsigned cnt_width(input int unsigned max_val);
      return (max_val < 2) ? 1 : $clog2(max_val + 1);
   endfunction

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
   parameter int              DATA_W    = 16,
   parameter logic [DATA_W-1:0] RESET_VAL = '1,
   parameter logic [DATA_W-1:0] IMPL     = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] src,
   output logic [DATA_W-1:0] mask_q,
   output logic              irq
);

   logic [DATA_W-1:0] pass;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= RESET_VAL;
      else if (clr)    mask_q <= RESET_VAL;
      else if (we)     mask_q <= wdata;
   end

   for (genvar i = 0; i < DATA_W; i++) begin : g_src
      if (IMPL[i]) begin : g_live
         assign pass[i] = src[i] & ~mask_q[i];
      end else begin : g_resv
         assign pass[i] = 1'b0;
      end
   end

   assign irq = |pass;

endmodule

// File: rtl/mon_pulse_timer.sv
module mon_pulse_timer
   import irq_rst_pkg::*;
#(
   parameter int unsigned CYCLES = 25_000_000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic start,
   output logic active
);

   localparam int unsigned CW = cnt_width(CYCLES);
   localparam logic [CW-1:0] LOAD = CW'(CYCLES - 1);

   logic [CW-1:0] cnt;

   if (CYCLES < 1) begin : g_bad_len
      $error("mon_pulse_timer: CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (clr) begin
         active <= 1'b0;
         cnt    <= '0;
      end else if (start) begin
         active <= 1'b1;
         cnt    <= LOAD;
      end else if (active) begin
         if (cnt == '0) active <= 1'b0;
         else           cnt    <= cnt - 1'b1;
      end
   end

endmodule

// File: rtl/sw_reset_gen.sv
module sw_reset_gen
   import irq_rst_pkg::*;
#(
   parameter int unsigned LEN = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   output logic req
);

   localparam int unsigned CW = cnt_width(LEN);

   logic [CW-1:0] cnt;

   if (LEN < 1) begin : g_bad_len
      $error("sw_reset_gen: LEN must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    cnt <= '0;
      else if (fire && cnt == '0)    cnt <= CW'(LEN);
      else if (cnt != '0)            cnt <= cnt - 1'b1;
   end

   assign req = (cnt != '0);

endmodule

// File: rtl/irq_rst_ctl.sv
module irq_rst_ctl
   import irq_rst_pkg::*;
#(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned MASK_ADDR  = 0,
   parameter int unsigned CTL_ADDR   = 1,
   parameter logic [DATA_W-1:0] MASK_RESET = 16'hFFFF,
   parameter logic [DATA_W-1:0] IMPL_SRC   = 16'h8FC3,
   parameter int unsigned MON_BIT    = 7,
   parameter int unsigned CODE_LSB   = 0,
   parameter int unsigned CODE_W     = 3,
   parameter logic [CODE_W-1:0] SW_CODE = 3'b101,
   parameter int unsigned CLK_HZ     = 50_000_000,
   parameter int unsigned MON_MS     = 500,
   parameter int unsigned MON_CYCLES = (CLK_HZ / 1000) * MON_MS,
   parameter int unsigned SW_LEN     = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [DATA_W-1:0] src_irq,
   output logic              irq_o,
   output logic              mon_rst_o,
   output logic              sw_rst_o
);

   localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(MASK_ADDR);
   localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(CTL_ADDR);
   localparam int unsigned CODE_MSB = CODE_LSB + CODE_W - 1;

   // elaboration-time parameter checks
   if (MASK_ADDR == CTL_ADDR) begin : g_chk_addr
      $error("irq_rst_ctl: register addresses collide");
   end
   if (MASK_ADDR >= (1 << ADDR_W) || CTL_ADDR >= (1 << ADDR_W)) begin : g_chk_aw
      $error("irq_rst_ctl: address does not fit ADDR_W");
   end
   if (MON_BIT >= DATA_W || CODE_MSB >= DATA_W) begin : g_chk_fld
      $error("irq_rst_ctl: control field outside data width");
   end
   if (MON_BIT >= CODE_LSB && MON_BIT <= CODE_MSB) begin : g_chk_ovl
      $error("irq_rst_ctl: monitor bit overlaps reset code field");
   end

   bus_act_t        act;
   logic            we_ok;
   logic            wr_ctl;
   logic [DATA_W-1:0] mask_q;

   // writes are dropped while the software reset is in force
   assign we_ok  = bus_we & ~sw_rst_o;
   assign wr_ctl = we_ok & (bus_addr == A_CTL);

   always_comb begin
      act.wr_mask   = we_ok & (bus_addr == A_MASK);
      act.code_hit  = wr_ctl & (bus_wdata[CODE_MSB:CODE_LSB] == SW_CODE);
      act.mon_start = wr_ctl & bus_wdata[MON_BIT] & ~act.code_hit;
   end

   irq_mask_bank #(
      .DATA_W    (DATA_W),
      .RESET_VAL (MASK_RESET),
      .IMPL      (IMPL_SRC)
   ) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sw_rst_o),
      .we     (act.wr_mask),
      .wdata  (bus_wdata),
      .src    (src_irq),
      .mask_q (mask_q),
      .irq    (irq_o)
   );

   mon_pulse_timer #(
      .CYCLES (MON_CYCLES)
   ) u_mon (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (sw_rst_o),
      .start  (act.mon_start),
      .active (mon_rst_o)
   );

   sw_reset_gen #(
      .LEN (SW_LEN)
   ) u_swr (
      .clk   (clk),
      .rst_n (rst_n),
      .fire  (act.code_hit),
      .req   (sw_rst_o)
   );

   // control register is write-only: only the mask reads back
   always_comb begin
      bus_rdata = '0;
      if (bus_addr == A_MASK) bus_rdata = mask_q;
   end

endmodule

// File: rtl/irq_rst_ctl_chk.sv
module irq_rst_ctl_chk #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 16,
   parameter int unsigned CTL_ADDR   = 1,
   parameter logic [DATA_W-1:0] MASK_RESET = 16'hFFFF,
   parameter logic [DATA_W-1:0] IMPL_SRC   = 16'h8FC3,
   parameter int unsigned MON_BIT    = 7,
   parameter int unsigned CODE_LSB   = 0,
   parameter int unsigned CODE_W     = 3,
   parameter logic [CODE_W-1:0] SW_CODE = 3'b101
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [DATA_W-1:0] bus_wdata,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] src_irq,
   input logic              irq_o,
   input logic              mon_rst_o,
   input logic              sw_rst_o,
   input logic [DATA_W-1:0] mask_q
);

   logic ctl_wr;
   logic code_ok;
   assign ctl_wr  = bus_we && !sw_rst_o && (bus_addr == ADDR_W'(CTL_ADDR));
   assign code_ok = bus_wdata[CODE_LSB +: CODE_W] == SW_CODE;

   p_all_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '1) |-> !irq_o);

   p_reserved_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_irq & IMPL_SRC) == '0) |-> !irq_o);

   p_ctl_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_W'(CTL_ADDR)) |-> (bus_rdata == '0));

   p_mon_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && bus_wdata[MON_BIT] && !code_ok) |=> mon_rst_o);

   p_sw_starts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && code_ok) |=> sw_rst_o);

   p_bad_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_wr && !code_ok) |=> !sw_rst_o);

   p_sw_restores_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_o |=> (mask_q == MASK_RESET));

   p_sw_stops_mon_r9: assert property (@(posedge clk) disable iff (!rst_n)
      sw_rst_o |=> !mon_rst_o);

endmodule

bind irq_rst_ctl irq_rst_ctl_chk #(
   .ADDR_W     (ADDR_W),
   .DATA_W     (DATA_W),
   .CTL_ADDR   (CTL_ADDR),
   .MASK_RESET (MASK_RESET),
   .IMPL_SRC   (IMPL_SRC),
   .MON_BIT    (MON_BIT),
   .CODE_LSB   (CODE_LSB),
   .CODE_W     (CODE_W),
   .SW_CODE    (SW_CODE)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .src_irq   (src_irq),
   .irq_o     (irq_o),
   .mon_rst_o (mon_rst_o),
   .sw_rst_o  (sw_rst_o),
   .mask_q    (mask_q)
);

// File: tb/sim_irq_rst_ctl.sv
`timescale 1ns/1ps
module sim_irq_rst_ctl;

   localparam int MONC = 40;
   localparam int SWL  = 4;
   localparam logic [3:0] AM = 4'd0;
   localparam logic [3:0] AC = 4'd1;
   localparam logic [15:0] IMPL = 16'h8FC3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [15:0] src_irq = '0;
   logic        irq_o, mon_rst_o, sw_rst_o;

   int n_cmp = 0;
   int n_bad = 0;
   logic [15:0] exp_mask;

   always #10 clk = ~clk;

   irq_rst_ctl #(.MON_CYCLES(MONC), .SW_LEN(SWL)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_irq(src_irq),
      .irq_o(irq_o), .mon_rst_o(mon_rst_o), .sw_rst_o(sw_rst_o));

   function automatic logic model_irq(input logic [15:0] s, input logic [15:0] m);
      return |(s & ~m & IMPL);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      tick();
      bus_we = 1'b0;
   endtask

   task automatic read_mask(input string tag, input logic [15:0] exp);
      bus_addr = AM; #1;
      chk(tag, bus_rdata, exp);
   endtask

   task automatic pulse_len(output int n);
      n = 0;
      while (mon_rst_o && n < 4*MONC) begin n++; tick(); end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
   end

   initial begin
      int n;
      logic [31:0] r;
      r = $urandom(32'h5EED);
      #35; rst_n = 1'b1; tick();

      // R1 reset state
      read_mask("R1 mask default", 16'hFFFF);
      chk("R1 irq", irq_o, 1'b0);
      chk("R1 mon", mon_rst_o, 1'b0);
      chk("R1 sw", sw_rst_o, 1'b0);
      src_irq = 16'hFFFF; #1;
      chk("R1 all masked irq", irq_o, 1'b0);

      // R5 control and unused addresses read zero
      bus_addr = AC; #1; chk("R5 ctl read", bus_rdata, 16'h0);
      bus_addr = 4'd9; #1; chk("R5 other read", bus_rdata, 16'h0);

      // R4 reserved positions
      bus_wr(AM, 16'h0000); exp_mask = 16'h0000;
      src_irq = 16'h703C; #1;
      chk("R4 reserved only", irq_o, 1'b0);
      src_irq = 16'h0002; #1;
      chk("R3 bit1 unmasked", irq_o, 1'b1);

      // R11 write strobe low
      bus_addr = AM; bus_wdata = 16'h1234; tick();
      read_mask("R11 mask kept", exp_mask);
      bus_addr = AC; bus_wdata = 16'h0085; tick();
      chk("R11 mon", mon_rst_o, 1'b0);
      chk("R11 sw", sw_rst_o, 1'b0);

      // R2/R3 random mask and source patterns
      for (int i = 0; i < 300; i++) begin
         if ($urandom % 3 == 0) begin
            exp_mask = 16'($urandom);
            bus_wr(AM, exp_mask);
            read_mask("R2 readback", exp_mask);
         end
         src_irq = 16'($urandom);
         if ($urandom % 2 == 0) src_irq = src_irq & 16'($urandom);
         #1;
         chk("R3 irq model", irq_o, model_irq(src_irq, exp_mask));
      end
      // directed single-source corners
      bus_wr(AM, 16'hFFFF & ~16'h8000); exp_mask = 16'h7FFF;
      src_irq = 16'h8000; #1; chk("R3 bit15 only", irq_o, 1'b1);
      src_irq = 16'h0F00; #1; chk("R3 masked others", irq_o, 1'b0);

      // R6 monitor pulse length
      bus_wr(AC, 16'h0080);
      chk("R6 mon rises", mon_rst_o, 1'b1);
      chk("R6 no sw", sw_rst_o, 1'b0);
      pulse_len(n);
      chk("R6 pulse length", n, MONC);

      // R7 restart
      bus_wr(AC, 16'h0080);
      repeat (10) tick();
      bus_wr(AC, 16'h0080);
      pulse_len(n);
      chk("R7 restarted length", n, MONC);

      // R8 non-matching codes
      for (int c = 0; c < 8; c++) begin
         if (c == 5) continue;
         bus_wr(AC, 16'(c));
         chk("R8 other code no sw", sw_rst_o, 1'b0);
      end
      chk("R8 other codes no mon", mon_rst_o, 1'b0);

      // R9 software reset: restores mask, kills pulse, ignores writes
      bus_wr(AM, 16'h0000); exp_mask = 16'h0000;
      bus_wr(AC, 16'h0080);
      repeat (3) tick();
      bus_wr(AC, 16'hFF05);
      chk("R8 sw rises", sw_rst_o, 1'b1);
      bus_addr = AM; bus_wdata = 16'h1234; bus_we = 1'b1;
      n = 0;
      while (sw_rst_o && n < 4*SWL) begin n++; tick(); end
      bus_we = 1'b0;
      chk("R8 sw length", n, SWL);
      exp_mask = 16'hFFFF;
      read_mask("R9 mask restored, write ignored", exp_mask);
      chk("R9 mon cleared", mon_rst_o, 1'b0);

      // R10 combined write starts only the software reset
      bus_wr(AC, 16'h0085);
      chk("R10 sw on", sw_rst_o, 1'b1);
      chk("R10 mon off", mon_rst_o, 1'b0);
      repeat (SWL + 2) tick();
      chk("R10 mon stays off", mon_rst_o, 1'b0);

      finish_run();
   end

endmodule